// File: doc/BRIEF.md
# Converter Parallel Readout Controller

This block is the digital half of a sampling converter's parallel output port. A host starts a conversion with an active-low start strobe. The block then holds a busy flag for a fixed number of clocks. At the end of that time it captures the result word offered by a stand-in conversion source. The result is unsigned straight binary: an input of zero gives 0x0000, midscale gives 0x8000, one step under midscale gives 0x7FFF and full scale gives 0xFFFF.

The host reads the captured word over a 16-bit bus, which has a data vector and an output-enable standing in for the tri-state pins. A 16-bit host reads the whole word in one access. An 8-bit host wires only the upper eight pins and reads twice, upper byte first, then lower byte with the byte-select raised. A start or chip-select falling edge that lands inside a running conversion aborts it. The abort clears the captured word and drops busy, which leaves the block ready for a new sample.

All host strobes are asynchronous. They pass through a synchronizer and an edge detector before they act.

Top module: `conv_readout_ctrl`

## Requirements
- R1: A completed conversion captures the supplied result word unchanged, including the codes 0xFFFF, 0x8000, 0x7FFF and 0x0000.
- R2: The bus is enabled (`dbus_oe` = 1) only while both `cs_n` and `rd_n` are low. For every other combination, `dbus_oe` is 0 and `dbus_out` is all zeros, which stands for high impedance.
- R3: With `byte_sel` low, `dbus_out[15:0]` carries the captured word bit for bit.
- R4: With `byte_sel` high, `dbus_out[15:8]` carries captured bits 7..0 and `dbus_out[7:0]` is 0xFF.
- R5: A two-step byte read returns the upper byte and then the lower byte on pins 15..8, whether `rd_n` is toggled between the steps or held low throughout.
- R6: A falling edge of `conv_n` while idle raises `busy` on the third rising clock edge after the input changes. `busy` then stays high for exactly CONV_CYCLES cycles, and the result word is captured on the edge where `busy` drops.
- R7: A falling edge of `conv_n` while `busy` is high and `cs_n` is low aborts the conversion. On the third edge after the input changes, `busy` goes low and the captured word becomes zero.
- R8: A falling edge of `cs_n` while `busy` is high aborts the conversion in the same way and with the same latency as R7.
- R9: An aborted conversion never captures its result word. The word stays zero and `busy` stays low until the next start.
- R10: A falling edge of `conv_n` during a conversion while `cs_n` is high is ignored. The conversion runs to its normal end and captures its result.
- R11: After reset, `busy` is low, the captured word is zero and the bus is disabled while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_n | input | 1 | Conversion start strobe, active on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | 0: full word, 1: low byte on upper pins |
| result_in | input | 16 | Result word from the conversion source |
| busy | output | 1 | High while a conversion runs |
| dbus_out | output | 16 | Bus data, zero when not enabled |
| dbus_oe | output | 1 | Bus output enable, stands in for tri-state control |

## Verification
Changes on the bus-control inputs (`cs_n`, `rd_n`, `byte_sel`) reach `dbus_out` and `dbus_oe` after the second rising edge. Start and abort edges act on the third rising edge. The result capture and the fall of `busy` come CONV_CYCLES edges after `busy` rises. The bench drives every input on a falling clock edge and counts whole cycles to the edge where a result is due. It samples on the falling edge after that one. Where the latency makes it meaningful, it also checks one cycle before the due edge, so that an early or late change is caught. The abort checks first load a nonzero word, so that the clearing and the lack of a later capture can be seen on the bus.

// File: rtl/convread_pkg.sv
package convread_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_CONV = 1'b1
   } phase_t;

   localparam int STROBE_CNT = 4;
   localparam int IDX_CONV   = 0;
   localparam int IDX_CS     = 1;
   localparam int IDX_RD     = 2;
   localparam int IDX_BYTE   = 3;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int                 WIDTH   = 4,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("strobe_sync needs at least two stages");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         logic              prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RST_VAL[b]}};
               prev  <= RST_VAL[b];
            end else begin
               chain <= {chain[STAGES-2:0], async_in[b]};
               prev  <= chain[STAGES-1];
            end
         end
         assign level[b] = chain[STAGES-1];
         assign fall[b]  = prev & ~chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import convread_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_fall,
   input  logic              cs_fall,
   input  logic              cs_lvl,
   input  logic [DATA_W-1:0] result_in,
   output logic              busy,
   output logic [DATA_W-1:0] word_q
);
   localparam int CNT_W = $clog2(CONV_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

   phase_t           phase;
   logic [CNT_W-1:0] remain;
   logic             abort;

   assign busy  = (phase == PH_CONV);
   assign abort = busy && (cs_fall || (start_fall && !cs_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         remain <= '0;
         word_q <= '0;
      end else if (abort) begin
         phase  <= PH_IDLE;
         remain <= '0;
         word_q <= '0;
      end else if (!busy) begin
         if (start_fall) begin
            phase  <= PH_CONV;
            remain <= CNT_LOAD;
         end
      end else if (remain == '0) begin
         phase  <= PH_IDLE;
         word_q <= result_in;
      end else begin
         remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/bus_byte_mux.sv
module bus_byte_mux #(
   parameter int DATA_W = 16
) (
   input  logic              cs_lvl,
   input  logic              rd_lvl,
   input  logic              byte_lvl,
   input  logic [DATA_W-1:0] word_q,
   output logic [DATA_W-1:0] dbus_out,
   output logic              dbus_oe
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] byte_view;

   generate
      if (HALF > 0) begin : g_split
         assign byte_view = {word_q[HALF-1:0], {HALF{1'b1}}};
      end
   endgenerate

   always_comb begin
      dbus_oe  = !cs_lvl && !rd_lvl;
      dbus_out = '0;
      if (dbus_oe) begin
         dbus_out = byte_lvl ? byte_view : word_q;
      end
   end
endmodule

// File: rtl/conv_readout_ctrl.sv
module conv_readout_ctrl
   import convread_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] result_in,
   output logic              busy,
   output logic [DATA_W-1:0] dbus_out,
   output logic              dbus_oe
);
   localparam logic [STROBE_CNT-1:0] SYNC_RST = 4'b0111;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be even and at least 2");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("CONV_CYCLES must be at least 1");
      end
   endgenerate

   logic [STROBE_CNT-1:0] raw_in, lvl, fall;
   logic                  start_fall, cs_fall, cs_lvl, rd_lvl, byte_lvl;
   logic [DATA_W-1:0]     word_q;

   assign raw_in[IDX_CONV] = conv_n;
   assign raw_in[IDX_CS]   = cs_n;
   assign raw_in[IDX_RD]   = rd_n;
   assign raw_in[IDX_BYTE] = byte_sel;

   strobe_sync #(
      .WIDTH  (STROBE_CNT),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw_in),
      .level   (lvl),
      .fall    (fall)
   );

   assign start_fall = fall[IDX_CONV];
   assign cs_fall    = fall[IDX_CS];
   assign cs_lvl     = lvl[IDX_CS];
   assign rd_lvl     = lvl[IDX_RD];
   assign byte_lvl   = lvl[IDX_BYTE];

   conv_sequencer #(
      .DATA_W     (DATA_W),
      .CONV_CYCLES(CONV_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_fall(start_fall),
      .cs_fall   (cs_fall),
      .cs_lvl    (cs_lvl),
      .result_in (result_in),
      .busy      (busy),
      .word_q    (word_q)
   );

   bus_byte_mux #(
      .DATA_W(DATA_W)
   ) u_mux (
      .cs_lvl  (cs_lvl),
      .rd_lvl  (rd_lvl),
      .byte_lvl(byte_lvl),
      .word_q  (word_q),
      .dbus_out(dbus_out),
      .dbus_oe (dbus_oe)
   );
endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [DATA_W-1:0] word_q,
   input logic [DATA_W-1:0] dbus_out,
   input logic              dbus_oe,
   input logic              byte_lvl,
   input logic              start_fall,
   input logic              cs_fall,
   input logic              cs_lvl
);
   localparam int HALF  = DATA_W / 2;
   localparam int RUN_W = $clog2(CONV_CYCLES + 1) + 1;

   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_fall)); // R6
   AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < RUN_W'(CONV_CYCLES))); // R6
   AST_WORD_HELD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(word_q)); // R9
   AST_ABORT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_fall && !cs_lvl) |=> (!busy && word_q == '0)); // R7
   AST_ABORT_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cs_fall) |=> (!busy && word_q == '0)); // R8
   AST_START_IGNORED_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_fall && cs_lvl && !cs_fall && run_cnt < RUN_W'(CONV_CYCLES - 1)) |=> busy); // R10
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dbus_oe |-> (dbus_out == '0)); // R2
   AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe && !byte_lvl) |-> (dbus_out == word_q)); // R3
   AST_BYTE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe && byte_lvl) |-> (dbus_out[DATA_W-1:HALF] == word_q[HALF-1:0]
                                 && dbus_out[HALF-1:0] == '1)); // R4
endmodule

bind conv_readout_ctrl conv_readout_chk #(
   .DATA_W     (DATA_W),
   .CONV_CYCLES(CONV_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .word_q    (word_q),
   .dbus_out  (dbus_out),
   .dbus_oe   (dbus_oe),
   .byte_lvl  (byte_lvl),
   .start_fall(start_fall),
   .cs_fall   (cs_fall),
   .cs_lvl    (cs_lvl)
);

// File: tb/conv_readout_ctrl_bench.sv
module conv_readout_ctrl_bench;
   localparam int C = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, byte_sel = 1'b0;
   logic [15:0] result_in = '0;
   logic        busy, dbus_oe;
   logic [15:0] dbus_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // each entry: {result word, expected byte-mode bus}
   localparam logic [31:0] VEC [5] = '{
      {16'hFFFF, 16'hFFFF},
      {16'h8000, 16'h00FF},
      {16'h7FFF, 16'hFFFF},
      {16'h0000, 16'h00FF},
      {16'hA55A, 16'h5AFF}
   };

   always #10 clk = ~clk;

   conv_readout_ctrl #(.DATA_W(16), .CONV_CYCLES(C), .SYNC_STAGES(2)) u_conv_readout_ctrl (
      .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
      .byte_sel(byte_sel), .result_in(result_in), .busy(busy),
      .dbus_out(dbus_out), .dbus_oe(dbus_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic [15:0] w, input string req);
      result_in = w;
      conv_n = 1'b0;
      tick(1);
      conv_n = 1'b1;
      tick(2);
      chk({req, " R6 busy rises on third edge"}, 16'(busy), 16'd1);
      tick(C - 1);
      chk({req, " R6 busy still high on last cycle"}, 16'(busy), 16'd1);
      tick(1);
      chk({req, " R6 busy drops after CONV_CYCLES"}, 16'(busy), 16'd0);
   endtask

   task automatic read_word(input logic [15:0] exp, input string req);
      rd_n = 1'b0; byte_sel = 1'b0;
      tick(2);
      chk({req, " oe"}, 16'(dbus_oe), 16'd1);
      chk(req, dbus_out, exp);
      rd_n = 1'b1;
      tick(2);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      // R11 reset state
      chk("R11 busy after reset", 16'(busy), 16'd0);
      chk("R11 bus off after reset", 16'(dbus_oe), 16'd0);
      cs_n = 1'b0; rd_n = 1'b0;
      tick(2);
      chk("R11 word zero after reset", dbus_out, 16'h0000);
      chk("R2 oe with cs and rd low", 16'(dbus_oe), 16'd1);
      rd_n = 1'b1;
      tick(2);
      chk("R2 oe off with rd high", 16'(dbus_oe), 16'd0);
      chk("R2 data zero with rd high", dbus_out, 16'h0000);
      cs_n = 1'b1; rd_n = 1'b0;
      tick(2);
      chk("R2 oe off with cs high", 16'(dbus_oe), 16'd0);
      rd_n = 1'b1; cs_n = 1'b0;
      tick(2);

      // table walk: R1, R3, R4, R5, R6
      for (int i = 0; i < 5; i++) begin
         run_conv(VEC[i][31:16], "R1");
         rd_n = 1'b0; byte_sel = 1'b0;
         tick(2);
         chk("R3 full word", dbus_out, VEC[i][31:16]);
         chk("R5 upper byte first step", {8'h00, dbus_out[15:8]}, {8'h00, VEC[i][31:24]});
         if (i % 2 == 0) begin
            rd_n = 1'b1; byte_sel = 1'b1;
            tick(2);
            chk("R5 toggled rd off between steps", 16'(dbus_oe), 16'd0);
            rd_n = 1'b0;
         end else begin
            byte_sel = 1'b1;
         end
         tick(2);
         chk("R4 byte mode bus", dbus_out, VEC[i][15:0]);
         chk("R5 lower byte second step", {8'h00, dbus_out[15:8]}, {8'h00, VEC[i][23:16]});
         rd_n = 1'b1; byte_sel = 1'b0;
         tick(2);
      end

      // R8 abort by chip select falling edge
      cs_n = 1'b1;
      tick(2);
      result_in = 16'h1357;
      conv_n = 1'b0; tick(1); conv_n = 1'b1; tick(2);
      chk("R8 busy before abort", 16'(busy), 16'd1);
      cs_n = 1'b0;
      tick(2);
      chk("R8 busy until third edge", 16'(busy), 16'd1);
      tick(1);
      chk("R8 busy cleared by cs edge", 16'(busy), 16'd0);
      read_word(16'h0000, "R8 word cleared");
      tick(C + 4);
      chk("R9 busy stays low", 16'(busy), 16'd0);
      read_word(16'h0000, "R9 aborted result not captured");

      // R7 abort by start edge with cs low
      run_conv(16'h2468, "R7 preload");
      result_in = 16'h9999;
      conv_n = 1'b0; tick(1); conv_n = 1'b1; tick(2);
      chk("R7 busy before abort", 16'(busy), 16'd1);
      conv_n = 1'b0; tick(1); conv_n = 1'b1;
      tick(1);
      chk("R7 busy until third edge", 16'(busy), 16'd1);
      tick(1);
      chk("R7 busy cleared by start edge", 16'(busy), 16'd0);
      read_word(16'h0000, "R7 word cleared");
      tick(C + 4);
      read_word(16'h0000, "R9 aborted result not captured after start abort");

      // R10 start edge ignored while deselected
      cs_n = 1'b1;
      tick(2);
      result_in = 16'h0F0F;
      conv_n = 1'b0; tick(1); conv_n = 1'b1; tick(2);
      chk("R10 busy up", 16'(busy), 16'd1);
      conv_n = 1'b0; tick(1); conv_n = 1'b1;
      tick(2);
      chk("R10 busy after ignored edge", 16'(busy), 16'd1);
      tick(C - 4);
      chk("R10 busy until normal end", 16'(busy), 16'd1);
      tick(1);
      chk("R10 busy drops at normal end", 16'(busy), 16'd0);
      cs_n = 1'b0;
      tick(2);
      read_word(16'h0F0F, "R10 result captured");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule